// File: doc/BRIEF.md
# Frame Interrupt Entry and Return Sequencer

This block sits beside the execution core of an 8-bit processor with a 16-bit address space. It turns a periodic frame tick into a complete interrupt entry. It also carries out the matching return sequence. The core owns the program counter, the stack pointer and the flags register. The sequencer reads their present values and asks the core to load new values through load strobes. It reaches memory through a single byte-wide port that has a read strobe, a write strobe, an address and write data.

On entry the sequencer pushes the resume address and the flags onto a downward-growing stack. It then loads the flags with only the interrupt-disable bit set. Finally it fetches the handler address from a two-byte vector in the top page. On the return request it pops the same three bytes in reverse order. Restoring the saved flags re-enables the interrupt.

A tick that arrives while interrupts are disabled is held as pending. It is taken once they are enabled again. A halt request parks the core until an entry happens. A request to clear the disable bit is refused while a handler is active. The block also owns the reset start state.

Top module: `frame_irq_seq`

## Requirements
- R1: While reset is held and in the first cycle after release, the block asserts `pcLoad` with `pcOut` = 0x0000 and `flagsLoad` with `flagsOut` = 0x10, where the interrupt-disable bit is bit 4 of the flags. It issues no memory strobe in that cycle.
- R2: No entry is started while flag bit 4 is set. A tick in that state causes no memory access and leaves `busy` low.
- R3: An entry writes three bytes on consecutive cycles. The PC high byte goes to SP-1, the PC low byte to SP-2 and the flags to SP-3. SP, PC and flags are the values present in the cycle before the first write.
- R4: In the cycle of the third write, the block asserts `spLoad` with `spOut` = SP-3 and `flagsLoad` with `flagsOut` = 0x10.
- R5: After the pushes, the block reads 0xFF00 and then 0xFF01. In the second of these reads it asserts `pcLoad` with `pcOut` = {byte at 0xFF01, byte at 0xFF00}.
- R6: A tick is remembered until it is taken. A tick seen while bit 4 is set, including a tick during a handler, starts an entry in the first idle cycle in which bit 4 is clear.
- R7: A return request reads SP, SP+1 and SP+2 on consecutive cycles. The first read loads the flags from the byte read. The third read loads the PC with {byte at SP+2, byte at SP+1} and loads SP+3 into the stack pointer.
- R8: A halt request raises `halted`, which stays high until an entry starts. If bit 4 is set, `halted` stays high and no memory access happens.
- R9: A clear-disable request outside a handler loads the flags with bit 4 cleared and the other bits kept. Between an entry and its return, the request produces no flags load.
- R10: `busy` is high during every entry or return cycle that drives memory, and while halted.
- R11: `memRd` and `memWr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameTick | input | 1 | One-cycle frame tick |
| haltReq | input | 1 | Core executes a halt |
| iretReq | input | 1 | Core requests interrupt return |
| cifReq | input | 1 | Core requests clearing the disable bit |
| pcIn | input | 16 | Current resume address |
| spIn | input | 16 | Current stack pointer |
| flagsIn | input | 8 | Current flags |
| memRdData | input | 8 | Read data, valid in the cycle of `memRd` |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | 16 | Memory address |
| memWrData | output | 8 | Memory write data |
| spLoad | output | 1 | Load `spOut` into the stack pointer |
| spOut | output | 16 | New stack pointer |
| pcLoad | output | 1 | Load `pcOut` into the PC |
| pcOut | output | 16 | New PC |
| flagsLoad | output | 1 | Load `flagsOut` into the flags |
| flagsOut | output | 8 | New flags |
| busy | output | 1 | Core must stall |
| halted | output | 1 | Core is parked by a halt |

## Verification
The bench goes after a tick that arrives while the disable bit is set. A design that drops such a tick would never enter the handler after the bit clears. It also sends a tick during a handler, which must cause a second entry as soon as the return restores a clear disable bit. A design that reversed the push order or the stack offsets would return to a swapped address or restore the wrong flags. Randomised PC, flags, stack and vector values expose this. The halt cases check that a halt with interrupts disabled never wakes. They also check that a clear-disable request inside a handler is refused; a design without that guard would open nested entries.

// File: rtl/frame_irq_pkg.sv
package frame_irq_pkg;

  typedef enum logic [3:0] {
    ST_BOOT,
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_PUSH_FLG,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_POP_FLG,
    ST_POP_LO,
    ST_POP_HI
  } seqState_t;

  typedef enum logic [2:0] {
    ADR_SP_M1,
    ADR_SP_M2,
    ADR_SP_M3,
    ADR_SP_P0,
    ADR_SP_P1,
    ADR_SP_P2,
    ADR_VEC_LO,
    ADR_VEC_HI
  } addrSel_t;

  typedef enum logic [1:0] {
    WD_PC_HI,
    WD_PC_LO,
    WD_FLAGS
  } wrSel_t;

  typedef enum logic {
    PCS_RESET,
    PCS_MEM
  } pcSel_t;

  typedef enum logic [1:0] {
    FLS_DISABLE_ONLY,
    FLS_MEM,
    FLS_CLEAR_IF
  } flagSel_t;

  typedef struct packed {
    logic     capture;
    logic     latchLow;
    addrSel_t addrSel;
    wrSel_t   wrSel;
    logic     spDown;
    pcSel_t   pcSel;
    flagSel_t flagSel;
  } seqCtrl_t;

endpackage

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl
  import frame_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameTick,
  input  logic     haltReq,
  input  logic     iretReq,
  input  logic     cifReq,
  input  logic     ifFlag,
  output seqCtrl_t ctrl,
  output logic     memRd,
  output logic     memWr,
  output logic     spLoad,
  output logic     pcLoad,
  output logic     flagsLoad,
  output logic     busy,
  output logic     halted
);

  seqState_t state, stateNext;
  logic pending;
  logic inHandler;
  logic haltedQ;
  logic startEntry;
  logic startReturn;

  assign startReturn = (state == ST_IDLE) && iretReq;
  assign startEntry  = (state == ST_IDLE) && !iretReq && !cifReq && !haltReq
                       && pending && !ifFlag;

  always_comb begin
    stateNext     = state;
    ctrl          = '0;
    ctrl.addrSel  = ADR_SP_M1;
    ctrl.wrSel    = WD_PC_HI;
    ctrl.pcSel    = PCS_MEM;
    ctrl.flagSel  = FLS_DISABLE_ONLY;
    memRd         = 1'b0;
    memWr         = 1'b0;
    spLoad        = 1'b0;
    pcLoad        = 1'b0;
    flagsLoad     = 1'b0;
    unique case (state)
      ST_BOOT: begin
        pcLoad       = 1'b1;
        ctrl.pcSel   = PCS_RESET;
        flagsLoad    = 1'b1;
        ctrl.flagSel = FLS_DISABLE_ONLY;
        stateNext    = ST_IDLE;
      end
      ST_IDLE: begin
        if (startReturn) begin
          ctrl.capture = 1'b1;
          stateNext    = ST_POP_FLG;
        end else if (cifReq) begin
          flagsLoad    = !inHandler;
          ctrl.flagSel = FLS_CLEAR_IF;
        end else if (startEntry) begin
          ctrl.capture = 1'b1;
          stateNext    = ST_PUSH_HI;
        end
      end
      ST_PUSH_HI: begin
        memWr        = 1'b1;
        ctrl.addrSel = ADR_SP_M1;
        ctrl.wrSel   = WD_PC_HI;
        stateNext    = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        memWr        = 1'b1;
        ctrl.addrSel = ADR_SP_M2;
        ctrl.wrSel   = WD_PC_LO;
        stateNext    = ST_PUSH_FLG;
      end
      ST_PUSH_FLG: begin
        memWr        = 1'b1;
        ctrl.addrSel = ADR_SP_M3;
        ctrl.wrSel   = WD_FLAGS;
        spLoad       = 1'b1;
        ctrl.spDown  = 1'b1;
        flagsLoad    = 1'b1;
        ctrl.flagSel = FLS_DISABLE_ONLY;
        stateNext    = ST_VEC_LO;
      end
      ST_VEC_LO: begin
        memRd         = 1'b1;
        ctrl.addrSel  = ADR_VEC_LO;
        ctrl.latchLow = 1'b1;
        stateNext     = ST_VEC_HI;
      end
      ST_VEC_HI: begin
        memRd        = 1'b1;
        ctrl.addrSel = ADR_VEC_HI;
        pcLoad       = 1'b1;
        ctrl.pcSel   = PCS_MEM;
        stateNext    = ST_IDLE;
      end
      ST_POP_FLG: begin
        memRd        = 1'b1;
        ctrl.addrSel = ADR_SP_P0;
        flagsLoad    = 1'b1;
        ctrl.flagSel = FLS_MEM;
        stateNext    = ST_POP_LO;
      end
      ST_POP_LO: begin
        memRd         = 1'b1;
        ctrl.addrSel  = ADR_SP_P1;
        ctrl.latchLow = 1'b1;
        stateNext     = ST_POP_HI;
      end
      ST_POP_HI: begin
        memRd        = 1'b1;
        ctrl.addrSel = ADR_SP_P2;
        pcLoad       = 1'b1;
        ctrl.pcSel   = PCS_MEM;
        spLoad       = 1'b1;
        ctrl.spDown  = 1'b0;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_BOOT;
      pending   <= 1'b0;
      inHandler <= 1'b0;
      haltedQ   <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= (pending && !startEntry) || frameTick;
      if (state == ST_PUSH_FLG) begin
        inHandler <= 1'b1;
      end else if (state == ST_POP_HI) begin
        inHandler <= 1'b0;
      end
      if (startEntry) begin
        haltedQ <= 1'b0;
      end else if (state == ST_IDLE && haltReq && !iretReq) begin
        haltedQ <= 1'b1;
      end
    end
  end

  assign halted = haltedQ;
  assign busy   = (state != ST_IDLE) || haltedQ;

endmodule

// File: rtl/frame_irq_dp.sv
module frame_irq_dp
  import frame_irq_pkg::*;
#(
  parameter int                    DATA_W   = 8,
  parameter logic [2*DATA_W-1:0]   VEC_ADDR = 16'hFF00,
  parameter logic [2*DATA_W-1:0]   RESET_PC = 16'h0000,
  parameter int                    IF_BIT   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtrl_t            ctrl,
  input  logic [2*DATA_W-1:0] spIn,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0]   flagsIn,
  input  logic [DATA_W-1:0]   memRdData,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [2*DATA_W-1:0] spOut,
  output logic [2*DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0]   flagsOut
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] IF_MASK = DATA_W'(1) << IF_BIT;
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(3);

  logic [ADDR_W-1:0] baseSp;
  logic [ADDR_W-1:0] savedPc;
  logic [DATA_W-1:0] savedFlags;
  logic [DATA_W-1:0] lowByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseSp     <= '0;
      savedPc    <= '0;
      savedFlags <= '0;
      lowByte    <= '0;
    end else begin
      if (ctrl.capture) begin
        baseSp     <= spIn;
        savedPc    <= pcIn;
        savedFlags <= flagsIn;
      end
      if (ctrl.latchLow) begin
        lowByte <= memRdData;
      end
    end
  end

  always_comb begin
    unique case (ctrl.addrSel)
      ADR_SP_M1:  memAddr = baseSp - ADDR_W'(1);
      ADR_SP_M2:  memAddr = baseSp - ADDR_W'(2);
      ADR_SP_M3:  memAddr = baseSp - ADDR_W'(3);
      ADR_SP_P0:  memAddr = baseSp;
      ADR_SP_P1:  memAddr = baseSp + ADDR_W'(1);
      ADR_SP_P2:  memAddr = baseSp + ADDR_W'(2);
      ADR_VEC_LO: memAddr = VEC_ADDR;
      ADR_VEC_HI: memAddr = VEC_ADDR + ADDR_W'(1);
      default:    memAddr = baseSp;
    endcase
  end

  always_comb begin
    unique case (ctrl.wrSel)
      WD_PC_HI: memWrData = savedPc[ADDR_W-1:DATA_W];
      WD_PC_LO: memWrData = savedPc[DATA_W-1:0];
      WD_FLAGS: memWrData = savedFlags;
      default:  memWrData = '0;
    endcase
  end

  always_comb begin
    unique case (ctrl.flagSel)
      FLS_DISABLE_ONLY: flagsOut = IF_MASK;
      FLS_MEM:          flagsOut = memRdData;
      FLS_CLEAR_IF:     flagsOut = flagsIn & ~IF_MASK;
      default:          flagsOut = IF_MASK;
    endcase
  end

  assign spOut = ctrl.spDown ? (baseSp - FRAME_BYTES) : (baseSp + FRAME_BYTES);
  assign pcOut = (ctrl.pcSel == PCS_RESET) ? RESET_PC : {memRdData, lowByte};

endmodule

// File: rtl/frame_irq_seq.sv
module frame_irq_seq
  import frame_irq_pkg::*;
#(
  parameter int                  DATA_W   = 8,
  parameter logic [2*DATA_W-1:0] VEC_ADDR = 16'hFF00,
  parameter logic [2*DATA_W-1:0] RESET_PC = 16'h0000,
  parameter int                  IF_BIT   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameTick,
  input  logic                haltReq,
  input  logic                iretReq,
  input  logic                cifReq,
  input  logic [2*DATA_W-1:0] pcIn,
  input  logic [2*DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0]   flagsIn,
  input  logic [DATA_W-1:0]   memRdData,
  output logic                memRd,
  output logic                memWr,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic                spLoad,
  output logic [2*DATA_W-1:0] spOut,
  output logic                pcLoad,
  output logic [2*DATA_W-1:0] pcOut,
  output logic                flagsLoad,
  output logic [DATA_W-1:0]   flagsOut,
  output logic                busy,
  output logic                halted
);

  seqCtrl_t ctrl;

  frame_irq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameTick (frameTick),
    .haltReq   (haltReq),
    .iretReq   (iretReq),
    .cifReq    (cifReq),
    .ifFlag    (flagsIn[IF_BIT]),
    .ctrl      (ctrl),
    .memRd     (memRd),
    .memWr     (memWr),
    .spLoad    (spLoad),
    .pcLoad    (pcLoad),
    .flagsLoad (flagsLoad),
    .busy      (busy),
    .halted    (halted)
  );

  frame_irq_dp #(
    .DATA_W   (DATA_W),
    .VEC_ADDR (VEC_ADDR),
    .RESET_PC (RESET_PC),
    .IF_BIT   (IF_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .spIn      (spIn),
    .pcIn      (pcIn),
    .flagsIn   (flagsIn),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .spOut     (spOut),
    .pcOut     (pcOut),
    .flagsOut  (flagsOut)
  );

endmodule

// File: rtl/frame_irq_seq_chk.sv
module frame_irq_seq_chk #(
  parameter int                  DATA_W   = 8,
  parameter logic [2*DATA_W-1:0] VEC_ADDR = 16'hFF00,
  parameter int                  IF_BIT   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic [DATA_W-1:0]   flagsIn,
  input logic [DATA_W-1:0]   memRdData,
  input logic                memRd,
  input logic                memWr,
  input logic [2*DATA_W-1:0] memAddr,
  input logic                spLoad,
  input logic [2*DATA_W-1:0] spOut,
  input logic                pcLoad,
  input logic [2*DATA_W-1:0] pcOut,
  input logic                flagsLoad,
  input logic [DATA_W-1:0]   flagsOut,
  input logic                busy,
  input logic                halted
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] IF_MASK = DATA_W'(1) << IF_BIT;
  localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_ADDR + ADDR_W'(1);

  AST_ONE_MEM_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R11

  AST_NO_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && flagsIn[IF_BIT]) |=> !memWr); // R2

  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && $past(memWr)) |-> (memAddr == $past(memAddr) - ADDR_W'(1))); // R3

  AST_ENTRY_FLAGS_SP: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && spLoad) |-> (flagsLoad && flagsOut == IF_MASK && spOut == memAddr)); // R4

  AST_VEC_LOW_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memWr)) |-> (memAddr == VEC_ADDR)); // R5

  AST_VEC_HIGH_PC: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd) && $past(memWr, 2)) |->
      (memAddr == VEC_HI_ADDR && pcLoad && pcOut[ADDR_W-1:DATA_W] == memRdData)); // R5

  AST_RETURN_SP: assert property (@(posedge clk) disable iff (!rstN)
    (spLoad && memRd) |-> (spOut == memAddr + ADDR_W'(1) && pcLoad)); // R7

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (halted && flagsIn[IF_BIT]) |=> halted); // R8

  AST_BUSY_ON_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> busy); // R10

endmodule

bind frame_irq_seq frame_irq_seq_chk #(
  .DATA_W   (DATA_W),
  .VEC_ADDR (VEC_ADDR),
  .IF_BIT   (IF_BIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .flagsIn   (flagsIn),
  .memRdData (memRdData),
  .memRd     (memRd),
  .memWr     (memWr),
  .memAddr   (memAddr),
  .spLoad    (spLoad),
  .spOut     (spOut),
  .pcLoad    (pcLoad),
  .pcOut     (pcOut),
  .flagsLoad (flagsLoad),
  .flagsOut  (flagsOut),
  .busy      (busy),
  .halted    (halted)
);

// File: tb/frame_irq_seq_bench.sv
`timescale 1ns/1ps
module frame_irq_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameTick = 1'b0;
  logic        haltReq = 1'b0;
  logic        iretReq = 1'b0;
  logic        cifReq = 1'b0;
  logic [15:0] pcIn, spIn, memAddr, spOut, pcOut;
  logic [7:0]  flagsIn, memRdData, memWrData, flagsOut;
  logic        memRd, memWr, spLoad, pcLoad, flagsLoad, busy, halted;

  logic [15:0] mPc, mSp;
  logic [7:0]  mFlags;
  logic [7:0]  mem [256];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign pcIn      = mPc;
  assign spIn      = mSp;
  assign flagsIn   = mFlags;
  assign memRdData = (memAddr[15:8] == 8'hFF) ? mem[memAddr[7:0]] : 8'h00;

  frame_irq_seq u_frame_irq_seq (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .haltReq(haltReq),
    .iretReq(iretReq), .cifReq(cifReq), .pcIn(pcIn), .spIn(spIn),
    .flagsIn(flagsIn), .memRdData(memRdData), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memWrData(memWrData), .spLoad(spLoad), .spOut(spOut),
    .pcLoad(pcLoad), .pcOut(pcOut), .flagsLoad(flagsLoad), .flagsOut(flagsOut),
    .busy(busy), .halted(halted)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: core model applies the loads seen now, returns at next negedge
  task automatic cyc();
    logic sPcL = pcLoad, sSpL = spLoad, sFlL = flagsLoad, sWr = memWr;
    logic [15:0] sPc = pcOut, sSp = spOut, sAd = memAddr;
    logic [7:0] sFl = flagsOut, sWd = memWrData;
    @(posedge clk);
    if (sPcL) mPc <= sPc;
    if (sSpL) mSp <= sSp;
    if (sFlL) mFlags <= sFl;
    if (sWr && sAd[15:8] == 8'hFF) mem[sAd[7:0]] <= sWd;
    @(negedge clk);
  endtask

  task automatic pulseTick();
    frameTick = 1'b1;
    cyc();
    frameTick = 1'b0;
  endtask

  function automatic logic [7:0] entryFlags();
    return 8'h10;
  endfunction

  // called in the cycle where entry begins
  task automatic entryCheck(input logic [15:0] vec);
    logic [15:0] bSp = mSp, bPc = mPc;
    logic [7:0]  bF = mFlags;
    cyc();
    chkEq("R3 pc-high write", {memWr, memRd, memAddr, memWrData}, {2'b10, bSp - 16'd1, bPc[15:8]});
    chkEq("R10 busy during entry", busy, 1);
    cyc();
    chkEq("R3 pc-low write", {memWr, memRd, memAddr, memWrData}, {2'b10, bSp - 16'd2, bPc[7:0]});
    cyc();
    chkEq("R3 flags write", {memWr, memRd, memAddr, memWrData}, {2'b10, bSp - 16'd3, bF});
    chkEq("R4 sp update", {spLoad, spOut}, {1'b1, bSp - 16'd3});
    chkEq("R4 flags cleared", {flagsLoad, flagsOut}, {1'b1, entryFlags()});
    cyc();
    chkEq("R5 vector low read", {memRd, memWr, memAddr}, {2'b10, 16'hFF00});
    cyc();
    chkEq("R5 vector high read", {memRd, memWr, memAddr}, {2'b10, 16'hFF01});
    chkEq("R5 pc load", {pcLoad, pcOut}, {1'b1, vec});
    cyc();
    chkEq("R5 core pc", mPc, vec);
    chkEq("R4 core sp and flags", {mSp, mFlags}, {bSp - 16'd3, entryFlags()});
    chkEq("R8 halted cleared by entry", halted, 0);
  endtask

  task automatic returnCheck(input logic [15:0] expPc, input logic [7:0] expF);
    logic [15:0] bSp = mSp;
    iretReq = 1'b1;
    cyc();
    iretReq = 1'b0;
    chkEq("R7 pop flags", {memRd, memWr, memAddr, flagsLoad, flagsOut}, {2'b10, bSp, 1'b1, expF});
    cyc();
    chkEq("R7 pop pc low", {memRd, memWr, memAddr}, {2'b10, bSp + 16'd1});
    cyc();
    chkEq("R7 pop pc high", {memRd, memAddr, pcLoad, pcOut}, {1'b1, bSp + 16'd2, 1'b1, expPc});
    chkEq("R7 sp restore", {spLoad, spOut}, {1'b1, bSp + 16'd3});
    cyc();
    chkEq("R7 core state", {mPc, mFlags, mSp}, {expPc, expF, bSp + 16'd3});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seedDummy;
    int quiet;
    seedDummy = $urandom(32'd2024);
    mPc <= 16'h5555; mSp <= 16'h0000; mFlags <= 8'h00;
    for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    @(negedge clk);
    repeat (3) cyc();
    rstN = 1'b1;
    #1;
    chkEq("R1 boot loads", {pcLoad, pcOut, flagsLoad, flagsOut}, {1'b1, 16'h0000, 1'b1, 8'h10});
    chkEq("R1 no memory in boot", {memRd, memWr}, 0);
    cyc();
    chkEq("R1 core after boot", {mPc, mFlags, busy}, {16'h0000, 8'h10, 1'b0});

    // tick while disabled: held, nothing happens
    mem[0] <= 8'h40; mem[1] <= 8'hA5; mPc <= 16'h1234;
    pulseTick();
    quiet = 1;
    for (int i = 0; i < 8; i++) begin
      if (memRd || memWr || busy) quiet = 0;
      cyc();
    end
    chkEq("R2 masked tick is silent", quiet, 1);
    mFlags <= 8'h00;
    #1;
    entryCheck(16'hA540); // R6 pending taken after enable

    // in handler: clear-disable refused, tick held
    cifReq = 1'b1;
    #1;
    chkEq("R9 cif ignored in handler", flagsLoad, 0);
    cyc();
    cifReq = 1'b0;
    chkEq("R9 flags still disabled", mFlags, 8'h10);
    pulseTick();
    returnCheck(16'h1234, 8'h00);
    entryCheck(16'hA540); // R6 second entry right after return
    returnCheck(16'h1234, 8'h00);

    // clear-disable outside handler
    mFlags <= 8'h15;
    #1;
    cifReq = 1'b1;
    #1;
    chkEq("R9 cif outside handler", {flagsLoad, flagsOut}, {1'b1, 8'h05});
    cyc();
    cifReq = 1'b0;
    chkEq("R9 core flags after cif", mFlags, 8'h05);

    // halt woken by the frame interrupt
    haltReq = 1'b1;
    cyc();
    haltReq = 1'b0;
    chkEq("R8 halted raised", {halted, busy}, 2'b11); // R10
    repeat (5) cyc();
    chkEq("R8 halt holds without tick", {halted, memRd, memWr}, 3'b100);
    mPc <= 16'h2001;
    pulseTick();
    entryCheck(16'hA540);
    returnCheck(16'h2001, 8'h05);

    // random entries and returns
    for (int it = 0; it < 30; it++) begin
      logic [15:0] rPc, rSp, rVec;
      logic [7:0]  rF;
      rPc  = 16'($urandom);
      rF   = 8'($urandom) & 8'hEF;
      rSp  = {8'hFF, 8'(($urandom % 240) + 8)};
      rVec = 16'($urandom);
      mPc <= rPc; mSp <= rSp; mFlags <= rF;
      mem[0] <= rVec[7:0]; mem[1] <= rVec[15:8];
      cyc();
      pulseTick();
      entryCheck(rVec);
      repeat ($urandom % 4) cyc();
      if (it % 3 == 0) begin
        pulseTick();
        returnCheck(rPc, rF);
        entryCheck(rVec); // R6
      end
      returnCheck(rPc, rF);
      cyc();
    end

    // halt with interrupts disabled never wakes
    mFlags <= 8'h10;
    #1;
    haltReq = 1'b1;
    cyc();
    haltReq = 1'b0;
    pulseTick();
    quiet = 1;
    for (int i = 0; i < 20; i++) begin
      if (!halted || memRd || memWr) quiet = 0;
      cyc();
    end
    chkEq("R8 disabled halt hangs", quiet, 1);

    rstN = 1'b0;
    cyc();
    rstN = 1'b1;
    #1;
    chkEq("R1 boot after second reset", {pcLoad, pcOut, flagsLoad, flagsOut, halted},
          {1'b1, 16'h0000, 1'b1, 8'h10, 1'b0});
    cyc();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule